// File: doc/BRIEF.md
# Basic-Mode DMA Channel Engine

This block is one DMA channel that moves a counted run of data items from a source region to a destination region, one item at a time, through a synchronous memory port with a one-cycle read latency. Software programs two inclusive end pointers and a 32-bit control word through a small register port, then enables the channel. A peripheral paces the work with a single request, which moves one item, or a burst request, which moves a whole arbitration group of 2^ARB items. After each group, the channel drops its bus hold so that other masters can be arbitrated.

Every item address is derived from an end pointer and the live remaining-item count, so nothing but the count changes while a transfer runs. Either side can step by 1, 2 or 4 bytes per item, or can stay on one fixed address such as a peripheral data register. Once the last item is written, the channel writes the stopped mode into its stored control word, drops its own enable and raises a one-cycle completion pulse. An optional burst-only setting makes the channel deaf to single requests.

Top module: `dma_basic_chan`

## Requirements
- R1: After a synchronous reset, all stored registers read as zero, and mem_re, mem_we, bus_hold and done are low.
- R2: A write to cfg_addr 0 stores the source end pointer, and a write to cfg_addr 1 stores the destination end pointer. A write to cfg_addr 2 stores the control word. cfg_rdata presents the register selected by cfg_addr one cycle later. At cfg_addr 3, a write with bit0 set enables the channel and a write with bit1 set disables it, with disable winning if both are set. Bit2 sets burst-only and bit3 clears it. A read of cfg_addr 3 returns enable in bit0, burst-only in bit1 and busy in bit2.
- R3: The control word layout is: destination step code in [31:30], destination item size in [29:28], source step code in [27:26], source item size in [25:24], ARB in [17:14], remaining-count-minus-one in [13:4] and mode in [2:0]. The count field counts down by one for each item moved, and reads back live.
- R4: With M = count field value and step code s in 0..2, the address of the next item is end_pointer − (M << s). Step code 3 holds the address at end_pointer for every item.
- R5: Each item is moved as a read strobe, then a wait cycle, then a write strobe carrying the read data. A read strobe is never high in the same cycle as a write strobe. mem_size carries the source size code on reads and the destination size code on writes.
- R6: A single request moves exactly one item. A burst request moves min(2^ARB, remaining) items, back to back.
- R7: bus_hold is high for every memory strobe. It falls after each group, and stays low for at least one cycle before the next group starts.
- R8: While burst-only is set, single requests start nothing and burst requests still start groups.
- R9: Requests start nothing while the channel is disabled, or while the mode field is not 1.
- R10: After the last item's write, the mode field reads 0 and the enable reads 0. done is high for exactly one cycle, in the cycle when the enable is first seen cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data |
| req_single | input | 1 | Peripheral single-item request |
| req_burst | input | 1 | Peripheral group request |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid the cycle after mem_re |
| mem_size | output | 2 | Item size code of the current access |
| bus_hold | output | 1 | Bus held for the current group |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets group truncation: a 10-item burst run with a group size of 4 must split into groups of 4, 4 and 2. A design that checked only the group counter would over-run the buffer, and one that checked only the count would never release the bus. The bench also covers single requests under burst-only, and requests while disabled or stopped; a leaky request filter shows up there as an unexpected memory strobe. Fixed-address and 2- and 4-byte-step sides check the end-pointer arithmetic, where an off-by-one in the remaining count shifts every address by one item. Completion is checked through the read-back mode field and the status enable, which catches a design that pulses done but leaves the channel armed.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int CTL_W     = 32;
  localparam int CNT_W     = 10;
  localparam int ARB_W     = 4;
  localparam int MODE_W    = 3;
  localparam int GRP_W     = 16;
  localparam int CNT_LSB   = 4;
  localparam int ARB_LSB   = 14;
  localparam int MODE_LSB  = 0;

  localparam logic [MODE_W-1:0] MODE_STOP  = 3'd0;
  localparam logic [MODE_W-1:0] MODE_BASIC = 3'd1;

  localparam logic [1:0] REG_SRC  = 2'd0;
  localparam logic [1:0] REG_DST  = 2'd1;
  localparam logic [1:0] REG_CTL  = 2'd2;
  localparam logic [1:0] REG_STAT = 2'd3;

  localparam logic [1:0] STEP_FIXED = 2'd3;

  typedef struct packed {
    logic [1:0]        dst_step;
    logic [1:0]        dst_size;
    logic [1:0]        src_step;
    logic [1:0]        src_size;
    logic [ARB_W-1:0]  arb;
    logic [CNT_W-1:0]  cnt;
    logic [MODE_W-1:0] mode;
  } ctl_fields_t;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RD   = 2'd1,
    SQ_WAIT = 2'd2,
    SQ_WR   = 2'd3
  } seq_state_t;

  function automatic ctl_fields_t split_ctl(input logic [CTL_W-1:0] w);
    ctl_fields_t f;
    f.dst_step = w[31:30];
    f.dst_size = w[29:28];
    f.src_step = w[27:26];
    f.src_size = w[25:24];
    f.arb      = w[ARB_LSB +: ARB_W];
    f.cnt      = w[CNT_LSB +: CNT_W];
    f.mode     = w[MODE_LSB +: MODE_W];
    return f;
  endfunction
endpackage

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] end_ptr,
  input  logic [CNT_W-1:0]  items_m1,
  input  logic [1:0]        step,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset = ADDR_W'(items_m1) << step;
    if (step == STEP_FIXED) begin
      addr = end_ptr;
    end else begin
      addr = end_ptr - offset;
    end
  end
endmodule

// File: rtl/dma_regs.sv
module dma_regs
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              busy,
  input  logic              cnt_dec,
  input  logic              fin,
  output logic [ADDR_W-1:0] src_end,
  output logic [ADDR_W-1:0] dst_end,
  output logic [CTL_W-1:0]  ctl_word,
  output logic              chan_en,
  output logic              burst_only
);
  logic [CNT_W-1:0] cnt_now;

  assign cnt_now = ctl_word[CNT_LSB +: CNT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      src_end    <= '0;
      dst_end    <= '0;
      ctl_word   <= '0;
      chan_en    <= 1'b0;
      burst_only <= 1'b0;
    end else begin
      if (cfg_we) begin
        case (cfg_addr)
          REG_SRC: src_end  <= ADDR_W'(cfg_wdata);
          REG_DST: dst_end  <= ADDR_W'(cfg_wdata);
          REG_CTL: ctl_word <= cfg_wdata;
          default: begin
            if (cfg_wdata[0]) chan_en <= 1'b1;
            if (cfg_wdata[1]) chan_en <= 1'b0;
            if (cfg_wdata[2]) burst_only <= 1'b1;
            if (cfg_wdata[3]) burst_only <= 1'b0;
          end
        endcase
      end
      // engine updates override same-cycle software writes
      if (cnt_dec) begin
        ctl_word[CNT_LSB +: CNT_W] <= cnt_now - CNT_W'(1);
      end
      if (fin) begin
        ctl_word[MODE_LSB +: MODE_W] <= MODE_STOP;
        chan_en                      <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else begin
      case (cfg_addr)
        REG_SRC: cfg_rdata <= 32'(src_end);
        REG_DST: cfg_rdata <= 32'(dst_end);
        REG_CTL: cfg_rdata <= ctl_word;
        default: cfg_rdata <= {29'd0, busy, burst_only, chan_en};
      endcase
    end
  end
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_fields_t       ctl,
  input  logic              chan_en,
  input  logic              burst_only,
  input  logic              req_single,
  input  logic              req_burst,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  output logic [CNT_W-1:0]  addr_cnt,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_re,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [1:0]        mem_size,
  output logic              bus_hold,
  output logic              done,
  output logic              cnt_dec,
  output logic              fin,
  output logic              busy
);
  seq_state_t       state;
  logic [GRP_W-1:0] grp_left;
  logic [GRP_W-1:0] grp_mask;
  logic             last_item;
  logic             start;

  assign last_item = (ctl.cnt == '0);
  assign grp_mask  = (GRP_W'(1) << ctl.arb) - GRP_W'(1);
  assign start     = chan_en && (ctl.mode == MODE_BASIC)
                     && (req_burst || (req_single && !burst_only));
  assign cnt_dec   = (state == SQ_WR) && !last_item;
  assign fin       = (state == SQ_WR) && last_item;
  assign busy      = (state != SQ_IDLE);

  // in the write cycle the next read already sees one item fewer
  always_comb begin
    if (state == SQ_WR) begin
      addr_cnt = ctl.cnt - CNT_W'(1);
    end else begin
      addr_cnt = ctl.cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      grp_left  <= '0;
      mem_re    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_size  <= '0;
      bus_hold  <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= fin;
      case (state)
        SQ_IDLE: begin
          if (start) begin
            mem_re   <= 1'b1;
            mem_addr <= src_addr;
            mem_size <= ctl.src_size;
            bus_hold <= 1'b1;
            grp_left <= req_burst ? grp_mask : '0;
            state    <= SQ_RD;
          end
        end
        SQ_RD: begin
          mem_re <= 1'b0;
          state  <= SQ_WAIT;
        end
        SQ_WAIT: begin
          mem_we    <= 1'b1;
          mem_wdata <= mem_rdata;
          mem_addr  <= dst_addr;
          mem_size  <= ctl.dst_size;
          state     <= SQ_WR;
        end
        default: begin
          mem_we <= 1'b0;
          if (last_item || (grp_left == '0)) begin
            bus_hold <= 1'b0;
            state    <= SQ_IDLE;
          end else begin
            grp_left <= grp_left - GRP_W'(1);
            mem_re   <= 1'b1;
            mem_addr <= src_addr;
            mem_size <= ctl.src_size;
            state    <= SQ_RD;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dma_basic_chan.sv
module dma_basic_chan
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              req_single,
  input  logic              req_burst,
  output logic              mem_re,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [1:0]        mem_size,
  output logic              bus_hold,
  output logic              done
);
  logic [ADDR_W-1:0] src_end;
  logic [ADDR_W-1:0] dst_end;
  logic [CTL_W-1:0]  ctl_word;
  ctl_fields_t       ctl;
  logic              chan_en;
  logic              burst_only;
  logic              busy;
  logic              cnt_dec;
  logic              fin;
  logic [CNT_W-1:0]  addr_cnt;
  logic [ADDR_W-1:0] src_addr;
  logic [ADDR_W-1:0] dst_addr;
  logic [1:0]        dst_step;
  logic              unused_ctl_bits;

  assign ctl             = split_ctl(ctl_word);
  assign dst_step        = ctl.dst_step;
  assign unused_ctl_bits = ^{ctl_word[23:18], ctl_word[3]};

  dma_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .busy       (busy),
    .cnt_dec    (cnt_dec),
    .fin        (fin),
    .src_end    (src_end),
    .dst_end    (dst_end),
    .ctl_word   (ctl_word),
    .chan_en    (chan_en),
    .burst_only (burst_only)
  );

  dma_addr_gen #(.ADDR_W(ADDR_W)) u_src_addr (
    .end_ptr  (src_end),
    .items_m1 (addr_cnt),
    .step     (ctl.src_step),
    .addr     (src_addr)
  );

  dma_addr_gen #(.ADDR_W(ADDR_W)) u_dst_addr (
    .end_ptr  (dst_end),
    .items_m1 (addr_cnt),
    .step     (ctl.dst_step),
    .addr     (dst_addr)
  );

  dma_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl),
    .chan_en    (chan_en),
    .burst_only (burst_only),
    .req_single (req_single),
    .req_burst  (req_burst),
    .src_addr   (src_addr),
    .dst_addr   (dst_addr),
    .addr_cnt   (addr_cnt),
    .mem_rdata  (mem_rdata),
    .mem_re     (mem_re),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_size   (mem_size),
    .bus_hold   (bus_hold),
    .done       (done),
    .cnt_dec    (cnt_dec),
    .fin        (fin),
    .busy       (busy)
  );
endmodule

// File: rtl/dma_basic_chk.sv
module dma_basic_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_re,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              bus_hold,
  input logic              done,
  input logic              chan_en,
  input logic              busy,
  input logic [ADDR_W-1:0] dst_end,
  input logic [1:0]        dst_step
);
  p_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && mem_we));

  p_rd_to_wr_r5: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> !mem_we ##1 mem_we);

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_re || mem_we) |-> bus_hold);

  p_fixed_dst_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_we && dst_step == 2'd3) |-> mem_addr == dst_end);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_disables_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !chan_en);

  p_quiet_off_r9: assert property (@(posedge clk) disable iff (rst)
    (!chan_en && !busy) |=> !mem_re);
endmodule

bind dma_basic_chan dma_basic_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mem_re   (mem_re),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .bus_hold (bus_hold),
  .done     (done),
  .chan_en  (chan_en),
  .busy     (busy),
  .dst_end  (dst_end),
  .dst_step (dst_step)
);

// File: tb/sim_dma_basic_chan.sv
module sim_dma_basic_chan;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_single = 1'b0;
  logic        req_burst = 1'b0;
  logic        mem_re, mem_we, bus_hold, done;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [1:0]  mem_size;

  int n_chk = 0;
  int n_fail = 0;
  int done_cnt = 0;
  int grp_run = 0;
  logic [31:0] q_rd[$];
  logic [31:0] q_wa[$];
  logic [31:0] q_wd[$];
  int          q_grp[$];
  logic [1:0]  exp_ssz = '0;
  logic [1:0]  exp_dsz = '0;

  always #10 clk = ~clk;

  dma_basic_chan u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_single(req_single), .req_burst(req_burst),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_size(mem_size),
    .bus_hold(bus_hold), .done(done)
  );

  function automatic logic [31:0] fm(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, a[15:0]};
  endfunction

  function automatic logic [31:0] mk(input logic [1:0] di, dz, si, sz,
                                     input logic [3:0] arb, input int cnt,
                                     input logic [2:0] mode);
    return {di, dz, si, sz, 6'd0, arb, 10'(cnt), 1'b0, mode};
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: one-cycle read latency
  always @(posedge clk) if (mem_re) mem_rdata <= fm(mem_addr);

  // reference comparison on every clock
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_re) begin
        if (q_rd.size() == 0) chk(0, "R9 unexpected read", mem_addr, 0);
        else begin
          logic [31:0] e;
          e = q_rd.pop_front();
          chk(mem_addr == e, "R4 read address", mem_addr, e);
          chk(mem_size == exp_ssz, "R5 read size", 32'(mem_size), 32'(exp_ssz));
        end
      end
      if (mem_we) begin
        if (q_wa.size() == 0) chk(0, "R9 unexpected write", mem_addr, 0);
        else begin
          logic [31:0] ea, ed;
          ea = q_wa.pop_front();
          ed = q_wd.pop_front();
          chk(mem_addr == ea, "R4 write address", mem_addr, ea);
          chk(mem_wdata == ed, "R5 write data", mem_wdata, ed);
          chk(mem_size == exp_dsz, "R5 write size", 32'(mem_size), 32'(exp_dsz));
        end
      end
      if (!bus_hold && (mem_re || mem_we)) chk(0, "R7 strobe without hold", 0, 1);
      if (bus_hold && mem_we) grp_run++;
      if (!bus_hold && grp_run > 0) begin
        q_grp.push_back(grp_run);
        grp_run = 0;
      end
      if (done) done_cnt++;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic setup(input logic [31:0] se, de, input logic [1:0] si, sz,
                       di, dz, input logic [3:0] arb, input int n);
    wr(2'd0, se);
    wr(2'd1, de);
    wr(2'd2, mk(di, dz, si, sz, arb, n - 1, 3'd1));
    exp_ssz = sz;
    exp_dsz = dz;
    for (int k = 0; k < n; k++) begin
      logic [31:0] ra, wa;
      ra = (si == 2'd3) ? se : se - (32'(n - 1 - k) << si);
      wa = (di == 2'd3) ? de : de - (32'(n - 1 - k) << di);
      q_rd.push_back(ra);
      q_wa.push_back(wa);
      q_wd.push_back(fm(ra));
    end
  endtask

  task automatic pulse_single();
    @(negedge clk); req_single = 1'b1;
    @(negedge clk); req_single = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic burst_until_done(input int base);
    @(negedge clk); req_burst = 1'b1;
    for (int i = 0; i < 200 && done_cnt == base; i++) @(negedge clk);
    req_burst = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_groups(input int g0, g1, g2, input string tag);
    int exp_n;
    exp_n = (g2 > 0) ? 3 : ((g1 > 0) ? 2 : 1);
    chk(q_grp.size() == exp_n, tag, q_grp.size(), exp_n);
    if (q_grp.size() == exp_n) begin
      chk(q_grp[0] == g0, tag, q_grp[0], g0);
      if (exp_n > 1) chk(q_grp[1] == g1, tag, q_grp[1], g1);
      if (exp_n > 2) chk(q_grp[2] == g2, tag, q_grp[2], g2);
    end
    q_grp.delete();
  endtask

  initial begin
    #(20 * 150000);
    chk(0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int d0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(!mem_re && !mem_we && !bus_hold && !done, "R1 outputs idle",
        {mem_re, mem_we, bus_hold, done}, 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk(v == 0, "R1 register zero", v, 0);
    end

    // R2/R3 register storage and field placement
    wr(2'd0, 32'h0100_013F); rd(2'd0, v); chk(v == 32'h0100_013F, "R2 src end", v, 32'h0100_013F);
    wr(2'd1, 32'h4000_0000); rd(2'd1, v); chk(v == 32'h4000_0000, "R2 dst end", v, 32'h4000_0000);
    wr(2'd2, mk(2'd3, 2'd0, 2'd0, 2'd0, 4'd2, 63, 3'd0));
    rd(2'd2, v);
    chk(v[13:4] == 10'd63 && v[17:14] == 4'd2 && v[31:30] == 2'd3, "R3 field layout", v, 32'hC000_83F0);
    wr(2'd3, 32'h5); rd(2'd3, v); chk(v[1:0] == 2'b11, "R2 status set", v, 3);
    wr(2'd3, 32'hA); rd(2'd3, v); chk(v[1:0] == 2'b00, "R2 status clear", v, 0);
    wr(2'd3, 32'h3); rd(2'd3, v); chk(v[0] == 1'b0, "R2 clear wins", v, 0);

    // R6 single requests: fixed destination, byte source
    setup(32'h0000_013F, 32'h4000_0000, 2'd0, 2'd0, 2'd3, 2'd0, 4'd2, 6);
    wr(2'd3, 32'h1);
    for (int i = 0; i < 3; i++) pulse_single();
    check_groups(1, 1, 1, "R6 single moves one");
    rd(2'd2, v); chk(v[13:4] == 10'd2, "R3 live count", 32'(v[13:4]), 2);
    d0 = done_cnt;
    for (int i = 0; i < 3; i++) pulse_single();
    q_grp.delete();
    chk(done_cnt == d0 + 1, "R10 one done", done_cnt, d0 + 1);
    rd(2'd3, v); chk(v[0] == 1'b0, "R10 enable cleared", v, 0);
    rd(2'd2, v); chk(v[2:0] == 3'd0, "R10 mode stopped", v, 0);
    chk(q_wa.size() == 0, "R6 all items moved", q_wa.size(), 0);
    pulse_single();
    chk(q_grp.size() == 0, "R9 stopped after done", q_grp.size(), 0);

    // R6/R7 burst with truncation: 10 items, group 4
    setup(32'h0000_2009, 32'h0000_3009, 2'd0, 2'd0, 2'd0, 2'd0, 4'd2, 10);
    wr(2'd3, 32'h1);
    burst_until_done(done_cnt);
    check_groups(4, 4, 2, "R7 group split");
    chk(q_wa.size() == 0, "R6 burst all moved", q_wa.size(), 0);

    // R8 burst-only filter
    setup(32'h0000_1004, 32'h0000_1804, 2'd0, 2'd0, 2'd0, 2'd0, 4'd1, 5);
    wr(2'd3, 32'h5);
    pulse_single();
    chk(q_grp.size() == 0 && q_wa.size() == 5, "R8 single ignored", q_wa.size(), 5);
    burst_until_done(done_cnt);
    check_groups(2, 2, 1, "R8 burst served");
    wr(2'd3, 32'h8);

    // R9 disabled channel and stopped mode
    wr(2'd2, mk(2'd0, 2'd0, 2'd0, 2'd0, 4'd2, 3, 3'd1));
    @(negedge clk); req_burst = 1'b1; req_single = 1'b1;
    repeat (12) @(negedge clk);
    req_burst = 1'b0; req_single = 1'b0;
    chk(q_grp.size() == 0, "R9 disabled ignores", q_grp.size(), 0);
    wr(2'd2, mk(2'd0, 2'd0, 2'd0, 2'd0, 4'd2, 3, 3'd0));
    wr(2'd3, 32'h1);
    @(negedge clk); req_burst = 1'b1;
    repeat (12) @(negedge clk);
    req_burst = 1'b0;
    chk(q_grp.size() == 0, "R9 mode zero ignores", q_grp.size(), 0);
    rd(2'd3, v); chk(v[2] == 1'b0, "R9 not busy", v, 0);
    wr(2'd3, 32'h2);

    // R4/R5 wide items: source 4-byte step, destination 2-byte step
    setup(32'h5000_000C, 32'h6000_0006, 2'd2, 2'd2, 2'd1, 2'd1, 4'd3, 4);
    wr(2'd3, 32'h1);
    burst_until_done(done_cnt);
    check_groups(4, 0, 0, "R4 wide single group");
    chk(q_wa.size() == 0, "R4 wide all moved", q_wa.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule